// File: doc/BRIEF.md
# I2C Byte-Handshake Master

This block is a register-controlled I2C bus master that moves one byte at a time. Software programs a control register, a status/mode register and a data register through a simple single-cycle write port, and reads them back through a combinational read port. The block drives open-drain SCL and SDA. It only pulls each line low or lets it go.

Software loads an address byte and writes the mode with the start request set. The block then issues a START and shifts the byte out MSB first. After the ninth clock, which is the acknowledge slot, it sets a pending flag, raises the interrupt if that is enabled, and parks with SCL low. Software then chooses the next bus action and clears the pending flag to launch it. The action is one of: another byte in the current direction, a repeated START (requested by rewriting the mode with the start bit set), or a STOP (requested by rewriting the mode with the start bit clear). The bit rate comes from a selectable coarse prescaler followed by a 4-bit divisor.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads 0x00, both line drivers are released and irq is low.
- R2: A write to status (select 1) with bit 5, bit 4 and bit 7 all set, while the bus is idle, generates a START: SDA falls while SCL is high. The block then sends the data register (select 2) MSB first. Status bit 5 reads 1 from the START until the STOP has completed.
- R3: A start request written while status bit 4 (serial output enable) is 0 leaves the bus idle, and status bit 5 stays 0.
- R4: After each byte and its acknowledge slot, control (select 0) bit 4 becomes 1 and SCL is held low. SCL stays low until software writes control with bit 4 = 0. Writing bit 4 = 1 neither sets the flag nor releases the bus.
- R5: irq equals control bit 4 AND control bit 5.
- R6: Status bit 0 holds the acknowledge bit sampled after the last transmitted byte: 1 for NACK, 0 for ACK.
- R7: In receive mode (status bits 7:6 = 10), releasing the pending flag after the address clocks in one byte. The byte lands in the data register. In the acknowledge slot the master pulls SDA low when control bit 7 is 1 and leaves it high (NACK) when it is 0.
- R8: Writing status with bit 5 = 0 while busy, then releasing the pending flag, produces a STOP: SDA rises while SCL is high. After that status bit 5 reads 0 and both lines are released.
- R9: Writing status with bit 5 = 1 while busy, then releasing the pending flag, produces a repeated START with no STOP in between, followed by the current data register as the address byte.
- R10: One bit lasts P*(d+1) clock cycles, where d is control bits 3:0 and P is 16 when control bit 6 is 0 and 512 when it is 1.
- R11: During data and acknowledge bits SDA changes only while SCL is low. The only SDA edges while SCL is high are the START and STOP conditions. SDA is sampled as SCL rises.
- R12: Status reads as {mode[1:0], busy, output-enable, 000, nack}, with mode 11 meaning master transmit and 10 meaning master receive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Byte-complete interrupt |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The bench runs a small I2C target model on the wired bus. It drives the target against the stall-after-every-byte handshake. It holds the bus parked for hundreds of cycles and counts SCL edges, which catches a design that runs on without the pending flag being cleared, or that lets a write of 1 release the bus. It checks that a repeated START comes out without an intervening STOP and resends the freshly loaded address, which a design that treated every mode rewrite as a STOP would break. It checks that the final read byte is NACKed and earlier ones ACKed, which catches an acknowledge generator that ignores the enable. It measures the bit period at both prescaler settings and counts every START/STOP edge on the bus, so a mistimed divisor or an SDA change during SCL high shows up as a wrong period or a spurious bus condition.

// File: rtl/i2cb_pkg.sv
// Shared definitions for the I2C byte master: register selects, field
// positions and the engine's state and continuation types.
package i2cb_pkg;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    // control register field positions
    localparam int C_ACK  = 7;
    localparam int C_PRE  = 6;
    localparam int C_IE   = 5;
    localparam int C_PEND = 4;

    // status register field positions
    localparam int S_MODE_HI = 7;
    localparam int S_REQ     = 5;
    localparam int S_OEN     = 4;
    localparam int S_NACK    = 0;

    // what the engine does when the pending flag is released
    typedef enum logic [1:0] {
        GO_NEXT    = 2'd0,
        GO_RESTART = 2'd1,
        GO_STOP    = 2'd2
    } go_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STA_HI,
        ST_STA_LO,
        ST_RS_PRE,
        ST_BIT,
        ST_HOLD,
        ST_STO_LO,
        ST_STO_SCL,
        ST_STO_END
    } eng_state_t;

endpackage

// File: rtl/i2cb_phase_gen.sv
// Phase tick generator. Emits one tick per quarter bit while enabled.
// Quarter bit = (prescaler/4)*(div+1) clock cycles.
// Assumes PRE_LO >= 8, so consecutive ticks are at least two cycles apart.
module i2cb_phase_gen #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = $clog2((PRE_HI / 4) * (1 << DIV_W)) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] mult;
    logic [CNT_W-1:0] limit;

    // quarter-bit length from the prescaler choice and the divisor
    always_comb begin
        base  = pre_sel ? CNT_W'(PRE_HI / 4) : CNT_W'(PRE_LO / 4);
        mult  = CNT_W'(div) + CNT_W'(1);
        limit = base * mult;
    end

    assign tick = run && (cnt >= limit - CNT_W'(1));

    // free-running count while enabled; restarts at zero whenever halted
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + CNT_W'(1);
    end

    // R10
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/i2cb_engine.sv
// Bus sequencer: generates START, repeated START, eight data bits plus an
// acknowledge slot, and STOP. Each bit takes four phase ticks, with SCL low
// for the first two and high for the last two. It parks with SCL low after
// every byte until 'go' arrives.
// Assumes 'go' is only pulsed while parked and 'start_req' only while idle.
module i2cb_engine
    import i2cb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start_req,
    input  logic       go,
    input  go_kind_t   go_kind,
    input  logic       rx_mode,
    input  logic       ack_en,
    input  logic [7:0] tx_byte,
    input  logic       sda_in,
    output logic       busy,
    output logic       run,
    output logic       byte_done,
    output logic       rx_done,
    output logic [7:0] rx_byte,
    output logic       nack_upd,
    output logic       nack_val,
    output logic       scl_low,
    output logic       sda_low
);
    eng_state_t st;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic       is_rx;
    logic       sda_drv;

    logic last_bit;
    assign last_bit = (bitn == 4'd8);

    // sequencing of bus conditions, bit phases and the parked state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ph      <= 2'd0;
            bitn    <= 4'd0;
            shreg   <= 8'h00;
            is_rx   <= 1'b0;
            sda_drv <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start_req) st <= ST_STA_HI;
                ST_RS_PRE: if (tick) st <= ST_STA_HI;
                ST_STA_HI: if (tick) st <= ST_STA_LO;
                ST_STA_LO: if (tick) begin
                    st      <= ST_BIT;
                    ph      <= 2'd0;
                    bitn    <= 4'd0;
                    shreg   <= tx_byte;
                    is_rx   <= 1'b0;
                    sda_drv <= 1'b1;
                end
                ST_BIT: if (tick) begin
                    if (ph == 2'd0)
                        sda_drv <= last_bit ? (is_rx && ack_en) : (!is_rx && !shreg[7]);
                    if (ph == 2'd1 && !last_bit)
                        shreg <= {shreg[6:0], sda_in};
                    if (ph == 2'd3) begin
                        ph <= 2'd0;
                        if (last_bit) st <= ST_HOLD;
                        else          bitn <= bitn + 4'd1;
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                ST_HOLD: if (go) begin
                    case (go_kind)
                        GO_RESTART: st <= ST_RS_PRE;
                        GO_STOP:    st <= ST_STO_LO;
                        default: begin
                            st    <= ST_BIT;
                            ph    <= 2'd0;
                            bitn  <= 4'd0;
                            shreg <= tx_byte;
                            is_rx <= rx_mode;
                        end
                    endcase
                end
                ST_STO_LO:  if (tick) st <= ST_STO_SCL;
                ST_STO_SCL: if (tick) st <= ST_STO_END;
                ST_STO_END: if (tick) st <= ST_IDLE;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    // strobes toward the register block
    always_comb begin
        byte_done = (st == ST_BIT) && tick && (ph == 2'd3) && last_bit;
        rx_done   = byte_done && is_rx;
        rx_byte   = shreg;
        nack_upd  = (st == ST_BIT) && tick && (ph == 2'd1) && last_bit && !is_rx;
        nack_val  = sda_in;
    end

    // open-drain line drive decoded from the state
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (st)
            ST_STA_LO:  sda_low = 1'b1;
            ST_RS_PRE:  scl_low = 1'b1;
            ST_BIT: begin
                scl_low = !ph[1];
                sda_low = sda_drv;
            end
            ST_HOLD: begin
                scl_low = 1'b1;
                sda_low = sda_drv;
            end
            ST_STO_LO: begin
                scl_low = 1'b1;
                sda_low = 1'b1;
            end
            ST_STO_SCL: sda_low = 1'b1;
            default: ;
        endcase
    end

    assign busy = (st != ST_IDLE);
    assign run  = (st != ST_IDLE) && (st != ST_HOLD);

    // R11
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BIT && !scl_low && $past(!scl_low)) |-> $stable(sda_low));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!scl_low && !sda_low));

endmodule

// File: rtl/i2c_byte_master.sv
// Register front end of the I2C byte master. It holds the control, status
// and data registers. It turns mode rewrites into START, repeated-START or
// STOP requests and releases the parked engine when software clears the
// pending flag. Assumes a single write port with one access per cycle.
module i2c_byte_master
    import i2cb_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       sda_in
);
    localparam int DIV_W = 4;

    logic             ack_en_q, pre_q, ie_q, pend_q;
    logic [DIV_W-1:0] div_q;
    logic [1:0]       mode_q;
    logic             oen_q, nack_q;
    logic [7:0]       data_q;
    go_kind_t         req_q;
    logic             start_p;

    logic       tick, busy, run, byte_done, rx_done, nack_upd, nack_val;
    logic [7:0] rx_byte;
    logic       wr_ctrl, wr_stat, wr_data, release_go;

    assign wr_ctrl    = reg_we && (reg_sel == SEL_CTRL);
    assign wr_stat    = reg_we && (reg_sel == SEL_STAT);
    assign wr_data    = reg_we && (reg_sel == SEL_DATA);
    assign release_go = wr_ctrl && pend_q && !reg_wdata[C_PEND];

    // register updates from software writes and engine strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_en_q <= 1'b0;
            pre_q    <= 1'b0;
            ie_q     <= 1'b0;
            pend_q   <= 1'b0;
            div_q    <= '0;
            mode_q   <= 2'b00;
            oen_q    <= 1'b0;
            nack_q   <= 1'b0;
            data_q   <= 8'h00;
            req_q    <= GO_NEXT;
            start_p  <= 1'b0;
        end else begin
            start_p <= 1'b0;
            if (wr_ctrl) begin
                ack_en_q <= reg_wdata[C_ACK];
                pre_q    <= reg_wdata[C_PRE];
                ie_q     <= reg_wdata[C_IE];
                div_q    <= reg_wdata[DIV_W-1:0];
            end
            if (release_go) begin
                pend_q <= 1'b0;
                req_q  <= GO_NEXT;
            end
            if (wr_stat) begin
                mode_q <= reg_wdata[S_MODE_HI -: 2];
                oen_q  <= reg_wdata[S_OEN];
                if (reg_wdata[S_REQ]) begin
                    if (!busy)
                        start_p <= reg_wdata[S_OEN] && reg_wdata[S_MODE_HI];
                    else
                        req_q <= GO_RESTART;
                end else if (busy) begin
                    req_q <= GO_STOP;
                end
            end
            if (wr_data)   data_q <= reg_wdata;
            if (rx_done)   data_q <= rx_byte;
            if (byte_done) pend_q <= 1'b1;
            if (nack_upd)  nack_q <= nack_val;
        end
    end

    // read mux
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {ack_en_q, pre_q, ie_q, pend_q, div_q};
            SEL_STAT: reg_rdata = {mode_q, busy, oen_q, 3'b000, nack_q};
            SEL_DATA: reg_rdata = data_q;
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign irq = pend_q && ie_q;

    i2cb_phase_gen #(
        .PRE_LO (PRE_LO),
        .PRE_HI (PRE_HI),
        .DIV_W  (DIV_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .pre_sel (pre_q),
        .div     (div_q),
        .tick    (tick)
    );

    i2cb_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_req (start_p),
        .go        (release_go),
        .go_kind   (req_q),
        .rx_mode   (mode_q == 2'b10),
        .ack_en    (ack_en_q),
        .tx_byte   (data_q),
        .sda_in    (sda_in),
        .busy      (busy),
        .run       (run),
        .byte_done (byte_done),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .nack_upd  (nack_upd),
        .nack_val  (nack_val),
        .scl_low   (scl_drive_low),
        .sda_low   (sda_drive_low)
    );

    // R4
    pend_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> scl_drive_low);

endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_drive_low, sda_drive_low;
    logic       slv_low = 1'b0;
    logic       scl_w, sda_w;

    assign scl_w = !scl_drive_low;
    assign sda_w = !(sda_drive_low || slv_low);

    always #2.5 clk = !clk;

    i2c_byte_master dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_in(sda_w)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    int n_start = 0, n_stop = 0, n_rise = 0, exp_start = 0, exp_stop = 0;
    int rise_prev = 0, rise_last = 0, bitc = 0, bytec = 0;
    logic done = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    logic reading = 1'b0, quiet = 1'b0, mst_ack = 1'b0;
    logic slave_ack = 1'b1;
    logic [7:0] shf = 8'h00, last_byte = 8'h00, sbyte = 8'h00;

    // fields: [17] read, [16] target acks address, [15:8] address, [7:0] payload
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 1'b1, 8'hA4, 8'h5A},
        {1'b0, 1'b1, 8'h3C, 8'hC3},
        {1'b0, 1'b0, 8'h72, 8'h00},
        {1'b1, 1'b1, 8'hA5, 8'h96},
        {1'b1, 1'b1, 8'h5B, 8'h01},
        {1'b1, 1'b0, 8'h11, 8'h00}
    };

    function automatic logic [7:0] tgt_byte(input int n);
        return n[0] ? sbyte : ~sbyte;
    endfunction

    // bus monitor and target model, evaluated between clock edges
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_scl = 1'b1; prev_sda = 1'b1; slv_low = 1'b0;
        end else begin
            if (prev_scl && scl_w && prev_sda && !sda_w) begin
                n_start++; bitc = 0; bytec = 0; reading = 1'b0; quiet = 1'b0;
            end else if (prev_scl && scl_w && !prev_sda && sda_w) begin
                n_stop++; slv_low = 1'b0;
            end else if (!prev_scl && scl_w) begin
                rise_prev = rise_last; rise_last = cyc; n_rise++;
                if (bitc < 8) shf = {shf[6:0], sda_w};
                else          mst_ack = sda_w;
                bitc++;
            end else if (prev_scl && !scl_w) begin
                if (bitc == 8) begin
                    last_byte = shf;
                    if (bytec == 0) reading = shf[0];
                    slv_low = (bytec == 0 || !reading) ? slave_ack : 1'b0;
                end else if (bitc == 9) begin
                    bitc = 0; bytec++;
                    if (reading && mst_ack) quiet = 1'b1;
                    slv_low = (reading && !quiet) ? !tgt_byte(bytec)[7] : 1'b0;
                end else if (reading && bytec > 0 && !quiet) begin
                    slv_low = !tgt_byte(bytec)[7 - bitc];
                end else begin
                    slv_low = 1'b0;
                end
            end
            prev_scl = scl_w; prev_sda = sda_w;
        end
    end

    // cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk); reg_sel = s; #1 d = reg_rdata;
    endtask

    task automatic wait_pend();
        logic [7:0] c; int k;
        k = 0;
        do begin rd(2'd0, c); k++; end while (!c[4] && k < 20000);
        if (!c[4]) chk(0, 1, "R4 pending flag never set");
    endtask

    task automatic stop_bus(input logic [7:0] stat_v, input logic [7:0] ctrl_v);
        logic [7:0] s; int k;
        wr(2'd1, stat_v); wr(2'd0, ctrl_v); exp_stop++;
        k = 0;
        do begin rd(2'd1, s); k++; end while (s[5] && k < 20000);
        chk(n_stop, exp_stop, "R8 STOP seen");
        chk(s[5], 0, "R8 busy cleared");
        chk({scl_drive_low, sda_drive_low}, 0, "R8 lines released");
    endtask

    initial begin
        logic [7:0] v;
        int r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); chk(v, 8'h00, "R1 control");
        rd(2'd1, v); chk(v, 8'h00, "R1 status");
        rd(2'd2, v); chk(v, 8'h00, "R1 data");
        chk({irq, scl_drive_low, sda_drive_low}, 0, "R1 outputs");

        // R4: writing 1 to the pending bit does not set it
        wr(2'd0, 8'h10); rd(2'd0, v); chk(v[4], 0, "R4 write-one ignored");

        // R3: start with output disabled is ignored
        wr(2'd2, 8'hA4); wr(2'd1, 8'hE0);
        repeat (40) @(negedge clk);
        rd(2'd1, v); chk(v[5], 0, "R3 busy stays 0");
        chk(n_start, 0, "R3 no START");

        // table walk
        for (int i = 0; i < 6; i++) begin
            logic       isrd, ack;
            logic [7:0] ad, pl, s, d;
            {isrd, ack, ad, pl} = VEC[i];
            slave_ack = ack; sbyte = pl;
            wr(2'd0, 8'hA0); wr(2'd2, ad);
            wr(2'd1, isrd ? 8'hB0 : 8'hF0); exp_start++;
            wait_pend();
            chk(n_start, exp_start, "R2 START seen");
            chk(last_byte, ad, "R2 address byte");
            rd(2'd1, s);
            chk(s, {isrd ? 2'b10 : 2'b11, 1'b1, 1'b1, 3'b000, !ack}, "R6 R12 status");
            if (ack && !isrd) begin
                wr(2'd2, pl); wr(2'd0, 8'hA0); wait_pend();
                chk(last_byte, pl, "R2 data byte");
                rd(2'd1, s); chk(s[0], 0, "R6 data ack");
            end
            if (ack && isrd) begin
                wr(2'd0, 8'h20); wait_pend();
                rd(2'd2, d); chk(d, pl, "R7 read byte");
                chk(mst_ack, 1, "R7 final NACK");
            end
            stop_bus(isrd ? 8'h90 : 8'hD0, isrd ? 8'h20 : 8'hA0);
        end

        // R4 R5: parked bus holds while pending
        slave_ack = 1'b1;
        wr(2'd0, 8'hA0); wr(2'd2, 8'hB2); wr(2'd1, 8'hF0); exp_start++;
        wait_pend();
        chk(irq, 1, "R5 irq with enable");
        r0 = n_rise;
        wr(2'd0, 8'hB0);
        repeat (300) @(negedge clk);
        chk(scl_drive_low, 1, "R4 SCL held low");
        chk(n_rise, r0, "R4 no clocks while pending");
        wr(2'd0, 8'h90);
        rd(2'd0, v); chk(v[4], 1, "R5 pending kept");
        chk(irq, 0, "R5 irq masked");
        stop_bus(8'hD0, 8'h80);

        // R9: repeated start
        r0 = n_stop;
        wr(2'd0, 8'hA0); wr(2'd2, 8'hA0); wr(2'd1, 8'hF0); exp_start++;
        wait_pend();
        wr(2'd2, 8'h12); wr(2'd0, 8'hA0); wait_pend();
        chk(last_byte, 8'h12, "R9 sub-address");
        sbyte = 8'h3E;
        wr(2'd2, 8'hA1); wr(2'd1, 8'hB0); wr(2'd0, 8'h20); exp_start++;
        wait_pend();
        chk(n_start, exp_start, "R9 restart seen");
        chk(n_stop, r0, "R9 no STOP before restart");
        chk(last_byte, 8'hA1, "R9 address after restart");
        wr(2'd0, 8'h20); wait_pend();
        rd(2'd2, v); chk(v, 8'h3E, "R9 read after restart");
        stop_bus(8'h90, 8'h20);

        // R7: ACK on non-final read byte, NACK on final
        sbyte = 8'h69;
        wr(2'd0, 8'hA0); wr(2'd2, 8'h5D); wr(2'd1, 8'hB0); exp_start++;
        wait_pend();
        wr(2'd0, 8'hA0); wait_pend();
        rd(2'd2, v); chk(v, 8'h69, "R7 first byte");
        chk(mst_ack, 0, "R7 master ACK");
        wr(2'd0, 8'h20); wait_pend();
        rd(2'd2, v); chk(v, 8'h96, "R7 second byte");
        chk(mst_ack, 1, "R7 master NACK");
        stop_bus(8'h90, 8'h20);

        // R10: bit period at divisor 2 and at the coarse prescaler
        wr(2'd0, 8'hA2); wr(2'd2, 8'hC8); wr(2'd1, 8'hF0); exp_start++;
        wait_pend();
        chk(rise_last - rise_prev, 48, "R10 period 16*(2+1)");
        stop_bus(8'hD0, 8'hA2);
        wr(2'd0, 8'hE0); wr(2'd2, 8'hC8); wr(2'd1, 8'hF0); exp_start++;
        wait_pend();
        chk(rise_last - rise_prev, 512, "R10 period 512");
        stop_bus(8'hD0, 8'hE0);

        // R11: no extra START/STOP conditions anywhere on the bus
        chk(n_start, exp_start, "R11 START count");
        chk(n_stop, exp_stop, "R11 STOP count");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule